// File: doc/BRIEF.md
# Four-Phase Instruction Pipeline Sequencer

This block splits a fast internal clock into four rotating phase slots. Four consecutive slots make up one instruction cycle. The phases order the work of a two-stage pipeline. While one instruction word is being fetched from program memory, the word fetched in the previous cycle sits in the instruction register and is executed. A stream without branches therefore retires one instruction per instruction cycle.

The execute logic outside this block can report a taken branch together with a target address. When it does, the program counter jumps to the target at the next cycle boundary. The word that had already been fetched is dropped and replaced by a no-operation slot, so a branch costs two instruction cycles.

Data memory strobes sit in fixed slots: the operand read in the second phase and the destination write in the fourth. A divided clock output marks the instruction-cycle rate.

Top module: `qphase_seq`

## Requirements
- R1: Exactly one bit of `q_ph` is high in every clock cycle. Bit 0 is phase 1 and bit 3 is phase 4. The phases advance 1→2→3→4→1, one per clock.
- R2: While reset is low, the outputs hold these values: `q_ph` = 4'b0001, `pc` = 0, `ir` = `NOP_WORD`, `force_nop` = 1, and `dm_rd` and `dm_wr` both low. The first instruction cycle after reset is therefore a forced no-operation.
- R3: `pc` changes only at the clock edge that ends phase 4, so the new value is visible from phase 1. Without a branch it steps by one, wrapping modulo 2^PC_W.
- R4: `pmem_addr` always equals `pc`. At the edge that ends phase 4, `ir` takes the value of `instr_in`, and it holds that value through the whole next instruction cycle.
- R5: In a cycle that is not a forced no-operation, `dm_rd` is high exactly during phase 2 and `dm_wr` exactly during phase 4.
- R6: `br_taken` is sampled at the edge that ends phase 4 of a cycle that is not a forced no-operation. When it is high at that edge, `pc` loads `br_target`, `ir` loads `NOP_WORD` and `force_nop` rises for the next cycle.
- R7: During a forced no-operation cycle, `ir` equals `NOP_WORD`, both data memory strobes stay low, and `br_taken` has no effect: `pc` steps by one at the end of that cycle.
- R8: With no branches, the word fetched at address A appears in `ir` during the cycle in which `pc` equals A+1. This gives one instruction per cycle.
- R9: `cyc_clk` is high during phases 1 and 2 and low during phases 3 and 4, a period of four clocks.
- R10: After a taken branch to T, the cycle that follows is a forced no-operation with `pc` = T. The cycle after that executes the word at T, with `force_nop` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, four per instruction cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_in | input | IW | Word read from program memory at `pmem_addr` |
| br_taken | input | 1 | Execute logic requests a jump; sampled at the end of phase 4 |
| br_target | input | PC_W | Jump destination |
| q_ph | output | 4 | One-hot phase strobes, bit 0 = phase 1 |
| pc | output | PC_W | Program counter |
| pmem_addr | output | PC_W | Program memory fetch address |
| ir | output | IW | Instruction register (word under execution) |
| force_nop | output | 1 | Current execute slot is a flushed no-operation |
| dm_rd | output | 1 | Data memory operand read strobe |
| dm_wr | output | 1 | Data memory destination write strobe |
| cyc_clk | output | 1 | Instruction-cycle clock output |

## Verification
The assertions assume that `br_taken`, `br_target` and `instr_in` are settled before each rising clock edge. They also assume that the program memory answers combinationally from `pmem_addr` within the same cycle. The bench satisfies this by changing inputs only at falling edges and by modelling program memory as a pure function of the address. Branch requests are held for a whole instruction cycle, which lets them coincide with the sampling edge. The bench also raises them deliberately during forced no-operation cycles, including the first cycle after reset, to show that they are ignored there.

// File: rtl/qphase_seq.sv
module qphase_seq #(
  parameter int            PC_W     = 13,
  parameter int            IW       = 14,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   instr_in,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  output logic [3:0]      q_ph,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] pmem_addr,
  output logic [IW-1:0]   ir,
  output logic            force_nop,
  output logic            dm_rd,
  output logic            dm_wr,
  output logic            cyc_clk
);
  localparam int NPH = 4;
  localparam int PHW = $clog2(NPH);

  logic [PHW-1:0] ph;
  logic           last_ph;
  logic           take_br;

  assign last_ph = (ph == PHW'(NPH - 1));
  assign take_br = br_taken & ~force_nop;

  always_ff @(posedge clk) begin
    if (!rst_n)       ph <= '0;
    else if (last_ph) ph <= '0;
    else              ph <= ph + 1'b1;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    assign q_ph[i] = (ph == PHW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      ir        <= NOP_WORD;
      force_nop <= 1'b1;
    end else if (last_ph) begin
      pc        <= take_br ? br_target : pc + 1'b1;
      ir        <= take_br ? NOP_WORD : instr_in;
      force_nop <= take_br;
    end
  end

  assign pmem_addr = pc;
  assign dm_rd     = q_ph[1] & ~force_nop;
  assign dm_wr     = q_ph[3] & ~force_nop;
  assign cyc_clk   = q_ph[0] | q_ph[1];
endmodule

// File: rtl/qphase_seq_chk.sv
module qphase_seq_chk #(
  parameter int            PC_W     = 13,
  parameter int            IW       = 14,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [IW-1:0]   instr_in,
  input logic            br_taken,
  input logic [PC_W-1:0] br_target,
  input logic [3:0]      q_ph,
  input logic [PC_W-1:0] pc,
  input logic [IW-1:0]   ir,
  input logic            force_nop,
  input logic            dm_rd,
  input logic            dm_wr,
  input logic            cyc_clk
);
  logic br_eff;
  assign br_eff = br_taken & ~force_nop;

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(q_ph) == 1); // R1
  AST_PHASE_1_2: assert property (@(posedge clk) disable iff (!rst_n) q_ph[0] |=> q_ph[1]); // R1
  AST_PHASE_2_3: assert property (@(posedge clk) disable iff (!rst_n) q_ph[1] |=> q_ph[2]); // R1
  AST_PHASE_3_4: assert property (@(posedge clk) disable iff (!rst_n) q_ph[2] |=> q_ph[3]); // R1
  AST_PHASE_4_1: assert property (@(posedge clk) disable iff (!rst_n) q_ph[3] |=> q_ph[0]); // R1
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !q_ph[3] |=> $stable(pc)); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (q_ph[3] && !br_eff) |=> pc == PC_W'($past(pc) + 1'b1)); // R3
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !q_ph[3] |=> $stable(ir)); // R4
  AST_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (q_ph[3] && !br_eff) |=> ir == $past(instr_in)); // R4
  AST_RD_SLOT: assert property (@(posedge clk) disable iff (!rst_n) dm_rd |-> (q_ph[1] && !force_nop)); // R5
  AST_WR_SLOT: assert property (@(posedge clk) disable iff (!rst_n) dm_wr |-> (q_ph[3] && !force_nop)); // R5
  AST_BR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (q_ph[3] && br_eff) |=> (pc == $past(br_target) && force_nop)); // R6
  AST_NOP_WORD: assert property (@(posedge clk) disable iff (!rst_n) force_nop |-> (ir == NOP_WORD && !dm_rd && !dm_wr)); // R7
  AST_CYC_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cyc_clk) |-> q_ph[0]); // R9
  AST_CYC_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(cyc_clk) |-> q_ph[2]); // R9
endmodule

bind qphase_seq qphase_seq_chk #(.PC_W(PC_W), .IW(IW), .NOP_WORD(NOP_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_in(instr_in), .br_taken(br_taken),
  .br_target(br_target), .q_ph(q_ph), .pc(pc), .ir(ir), .force_nop(force_nop),
  .dm_rd(dm_rd), .dm_wr(dm_wr), .cyc_clk(cyc_clk)
);

// File: tb/qphase_seq_bench.sv
module qphase_seq_bench;
  localparam int PC_W = 13;
  localparam int IW   = 14;
  localparam logic [IW-1:0] NOPW = '0;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [IW-1:0]   instr_in;
  logic            br_taken = 1'b0;
  logic [PC_W-1:0] br_target = '0;
  logic [3:0]      q_ph;
  logic [PC_W-1:0] pc, pmem_addr;
  logic [IW-1:0]   ir;
  logic            force_nop, dm_rd, dm_wr, cyc_clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [IW-1:0] word_at(input logic [PC_W-1:0] a);
    return {1'b1, a};
  endfunction

  assign instr_in = word_at(pmem_addr);

  qphase_seq u_qphase_seq (
    .clk(clk), .rst_n(rst_n), .instr_in(instr_in), .br_taken(br_taken),
    .br_target(br_target), .q_ph(q_ph), .pc(pc), .pmem_addr(pmem_addr),
    .ir(ir), .force_nop(force_nop), .dm_rd(dm_rd), .dm_wr(dm_wr), .cyc_clk(cyc_clk)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Entered at the falling edge inside phase 1; leaves at the falling edge inside the next phase 1.
  task automatic run_cycle(input logic [PC_W-1:0] e_pc, input logic [IW-1:0] e_ir,
                           input bit e_nop, input bit br, input logic [PC_W-1:0] tgt);
    br_taken  = br;
    br_target = tgt;
    for (int p = 0; p < 4; p++) begin
      if (p > 0) @(negedge clk);
      chk(q_ph == 4'(1 << p), "R1 phase", q_ph, 4'(1 << p));
      chk(cyc_clk == (p < 2), "R9 cyc_clk", cyc_clk, (p < 2));
      chk(pc == e_pc, "R3 pc", pc, e_pc);
      chk(pmem_addr == e_pc, "R4 pmem_addr", pmem_addr, e_pc);
      chk(ir == e_ir, e_nop ? "R7 ir nop" : "R8 ir", ir, e_ir);
      chk(force_nop == e_nop, "R10 force_nop", force_nop, e_nop);
      chk(dm_rd == (p == 1 && !e_nop), e_nop ? "R7 dm_rd" : "R5 dm_rd", dm_rd, (p == 1 && !e_nop));
      chk(dm_wr == (p == 3 && !e_nop), e_nop ? "R7 dm_wr" : "R5 dm_wr", dm_wr, (p == 3 && !e_nop));
    end
    @(negedge clk);
    br_taken = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(q_ph == 4'b0001, "R2 q_ph", q_ph, 1);
    chk(pc == '0, "R2 pc", pc, 0);
    chk(ir == NOPW, "R2 ir", ir, NOPW);
    chk(force_nop == 1'b1, "R2 force_nop", force_nop, 1);
    chk(!dm_rd && !dm_wr, "R2 strobes", {dm_rd, dm_wr}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_sequential();
    // R7: branch request during the post-reset forced slot is ignored
    run_cycle(13'd0, NOPW, 1, 1, 13'h100);
    for (int a = 1; a <= 5; a++)
      run_cycle(PC_W'(a), word_at(PC_W'(a - 1)), 0, 0, '0); // R8
  endtask

  task automatic t_branch();
    run_cycle(13'd6, word_at(13'd5), 0, 1, 13'h0A0);          // R6
    run_cycle(13'h0A0, NOPW, 1, 1, 13'h155);                 // R7 ignored
    run_cycle(13'h0A1, word_at(13'h0A0), 0, 0, '0);          // R10
    run_cycle(13'h0A2, word_at(13'h0A1), 0, 1, 13'h040);     // R6 back-to-back
    run_cycle(13'h040, NOPW, 1, 0, '0);
    run_cycle(13'h041, word_at(13'h040), 0, 0, '0);          // R10
  endtask

  task automatic t_wrap();
    run_cycle(13'h042, word_at(13'h041), 0, 1, 13'h1FFF);    // R6
    run_cycle(13'h1FFF, NOPW, 1, 0, '0);
    run_cycle(13'h0000, word_at(13'h1FFF), 0, 0, '0);        // R3 wrap
    run_cycle(13'h0001, word_at(13'h0000), 0, 0, '0);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_branch();
    t_wrap();
    wrap_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    wrap_up();
  end
endmodule